// File: doc/BRIEF.md
# Greedy Tree-Search Candidate Generator

This block produces the candidate list for one soft-output MIMO detection problem. It takes the real-valued upper-triangular channel factor `R` and the rotated receive vector of a problem with `NT` complex antennas. The real and imaginary parts of each complex symbol sit in neighbouring dimensions, so there are `L = 2*NT` real levels. The block then searches a tree from level `L-1` down to level 0. The two top levels, which belong to one complex antenna, are enumerated exhaustively, which gives exactly `M` starting paths. Each path below that keeps a single child. The child is the alphabet point nearest to the zero-forcing estimate, and it is found by rounding to the odd-integer grid and then clamping. No sorting is done anywhere, so every path costs the same number of cycles.

`R`, the rotated vector and a precomputed reciprocal of each diagonal entry are written through a load port while the block is idle. A start strobe then launches the search. One datapath handles one level per cycle, and it works through the paths one after another. Every finished path appears on the output as a candidate with its index, its accumulated squared distance and its symbols. A done pulse closes the list. The downstream LLR stage takes all `M` candidates.

Top module: `ts_cand_gen`

## Requirements
- R1: While reset is held, and afterwards until the first start, `cand_valid_o`, `done_o`, `cand_idx_o`, `cand_dist_o` and `cand_sym_o` are all zero.
- R2: Path `k` takes the symbol `2*(k / Q) - (Q-1)` at level `L-1` and the symbol `2*(k mod Q) - (Q-1)` at level `L-2`, where `Q = sqrt(M)`.
- R3: At each level `t < L-2`, let `b = y[t] - sum over j>t of r[t][j]*s[j]` in units of 2^-12, and let `z = b * inv[t]` in units of 2^-24. The chosen symbol is `2*floor(z / 2^25) + 1`, clamped to the range from `-(Q-1)` to `Q-1`. An estimate that lies exactly on an even integer resolves upward.
- R4: The distance of a candidate is the sum over all levels of `(b - r[t][t]*s[t])^2`, reported as an unsigned integer in units of 2^-24.
- R5: When the distance would exceed `2^DIST_W - 1` at any level, it holds that maximum value for the rest of the path.
- R6: The cycle at which start is accepted counts as cycle 0. The candidate for path `k` is valid in the cycle after clock edge `L*(k+1)` and is high for one cycle. All `M` paths are reported in index order, and none is dropped.
- R7: `done_o` pulses for exactly one cycle, in the cycle right after the last candidate, and is never high together with `cand_valid_o`.
- R8: While a search runs, `start_i` and every load write are ignored. The search in progress continues unchanged, and later searches use the values that were stored before it.
- R9: A load write presented in the same cycle as an accepted start is stored, and that search uses it.
- R10: Load select codes: 0 writes `r[row][col]`, 1 writes `y[row]`, 2 writes `inv[row]`, and 3 has no effect. `cand_sym_o[t*SW +: SW]` holds the two's-complement symbol of level `t`, where `SW = log2(Q)+1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Load write strobe |
| ld_sel_i | input | 2 | Target of the write: matrix, vector, reciprocal or none |
| ld_row_i | input | log2(2*NT) | Row or level index |
| ld_col_i | input | log2(2*NT) | Column index for matrix writes |
| ld_data_i | input | DATA_W | Signed fixed-point value with FRAC_W fraction bits |
| start_i | input | 1 | Launch a search; taken only when idle |
| cand_valid_o | output | 1 | Candidate present |
| cand_idx_o | output | log2(M) | Path index of the candidate |
| cand_dist_o | output | DIST_W | Saturated squared distance, units of 2^-24 |
| cand_sym_o | output | 2*NT*SW | Symbols of all levels, level t at bits t*SW |
| done_o | output | 1 | Single-cycle pulse after the last candidate |

## Verification
Two things can land on the same clock edge: a write on the load port and the start strobe. When both arrive while the block is idle, the write must be stored and seen by the search it opens. When they arrive during a search, both must be dropped. The bench drives both cases: a write paired with start, and a start plus a write injected mid-search. It then judges the results against a behavioural model, comparing every cycle, and follows up with a second search without reloading, which shows at the outputs whether the injected write left the stored coefficients untouched.

// File: rtl/ts_pkg.sv
package ts_pkg;

  typedef enum logic [1:0] {
    LD_RMAT  = 2'd0,
    LD_RXV   = 2'd1,
    LD_RECIP = 2'd2,
    LD_NOP   = 2'd3
  } ld_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ts_state_e;

endpackage

// File: rtl/ts_coef_store.sv
module ts_coef_store
  import ts_pkg::*;
#(
  parameter int L      = 4,
  parameter int DATA_W = 16,
  localparam int LW    = $clog2(L)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [1:0]               sel_i,
  input  logic [LW-1:0]            row_i,
  input  logic [LW-1:0]            col_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic signed [DATA_W-1:0] r_o   [L][L],
  output logic signed [DATA_W-1:0] y_o   [L],
  output logic signed [DATA_W-1:0] inv_o [L]
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < L; i++) begin
        y_o[i]   <= '0;
        inv_o[i] <= '0;
        for (int j = 0; j < L; j++) r_o[i][j] <= '0;
      end
    end else if (wr_en_i) begin
      case (ld_sel_e'(sel_i))
        LD_RMAT:  r_o[row_i][col_i] <= data_i;
        LD_RXV:   y_o[row_i]        <= data_i;
        LD_RECIP: inv_o[row_i]      <= data_i;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/ts_level_pe.sv
module ts_level_pe #(
  parameter int L      = 4,
  parameter int Q      = 4,
  parameter int DATA_W = 16,
  parameter int FRAC_W = 12,
  parameter int PART_W = 48,
  localparam int LW    = $clog2(L),
  localparam int QB    = $clog2(Q),
  localparam int SYM_W = QB + 1
) (
  input  logic [LW-1:0]            lvl_i,
  input  logic                     top_i,
  input  logic signed [SYM_W-1:0]  top_sym_i,
  input  logic signed [DATA_W-1:0] r_row_i    [L],
  input  logic signed [DATA_W-1:0] y_i,
  input  logic signed [DATA_W-1:0] inv_i,
  input  logic signed [SYM_W-1:0]  path_sym_i [L],
  output logic signed [SYM_W-1:0]  sym_o,
  output logic [PART_W-1:0]        part_o
);

  localparam int EW    = PART_W / 2;
  localparam int ACC_W = EW - 2;
  localparam int ZW    = ACC_W + DATA_W;
  localparam int SHR   = 2 * FRAC_W + 1;
  localparam logic signed [ZW-1:0] F_HI = ZW'(Q/2 - 1);
  localparam logic signed [ZW-1:0] F_LO = ZW'(-(Q/2));

  logic signed [ACC_W-1:0]  acc;
  logic signed [ZW-1:0]     zf;
  logic signed [ZW-1:0]     fl;
  logic signed [EW-1:0]     err;
  logic signed [PART_W-1:0] sq;

  // interference cancellation over already decided levels
  always_comb begin
    acc = ACC_W'(y_i);
    for (int j = 0; j < L; j++) begin
      if (j > int'(lvl_i)) acc = acc - ACC_W'(r_row_i[j]) * ACC_W'(path_sym_i[j]);
    end
  end

  // zero-forcing estimate, floor onto odd grid, clamp to alphabet
  always_comb begin
    zf = ZW'(acc) * ZW'(inv_i);
    fl = zf >>> SHR;
    if (top_i)          sym_o = top_sym_i;
    else if (fl > F_HI) sym_o = SYM_W'(Q - 1);
    else if (fl < F_LO) sym_o = SYM_W'(-(Q - 1));
    else                sym_o = {fl[QB-1:0], 1'b1};
  end

  always_comb begin
    err    = EW'(acc) - EW'(r_row_i[lvl_i]) * EW'(sym_o);
    sq     = PART_W'(err) * PART_W'(err);
    part_o = sq;
  end

endmodule

// File: rtl/ts_sat_acc.sv
module ts_sat_acc #(
  parameter int IN_W = 48,
  parameter int DW   = 32
) (
  input  logic [DW-1:0]   base_i,
  input  logic [IN_W-1:0] add_i,
  output logic [DW-1:0]   sum_o
);

  localparam int SW = ((IN_W > DW) ? IN_W : DW) + 1;
  localparam logic [SW-1:0] LIMIT = SW'({DW{1'b1}});

  logic [SW-1:0] sum_w;

  always_comb begin
    sum_w = SW'(base_i) + SW'(add_i);
    sum_o = (sum_w > LIMIT) ? {DW{1'b1}} : sum_w[DW-1:0];
  end

endmodule

// File: rtl/ts_cand_gen.sv
module ts_cand_gen
  import ts_pkg::*;
#(
  parameter int NT     = 2,
  parameter int M      = 16,
  parameter int DATA_W = 16,
  parameter int FRAC_W = 12,
  parameter int DIST_W = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 ld_valid_i,
  input  logic [1:0]                           ld_sel_i,
  input  logic [$clog2(2*NT)-1:0]              ld_row_i,
  input  logic [$clog2(2*NT)-1:0]              ld_col_i,
  input  logic [DATA_W-1:0]                    ld_data_i,
  input  logic                                 start_i,
  output logic                                 cand_valid_o,
  output logic [$clog2(M)-1:0]                 cand_idx_o,
  output logic [DIST_W-1:0]                    cand_dist_o,
  output logic [2*NT*($clog2(M)/2+1)-1:0]      cand_sym_o,
  output logic                                 done_o
);

  localparam int L      = 2 * NT;
  localparam int LW     = $clog2(L);
  localparam int KW     = $clog2(M);
  localparam int QB     = KW / 2;
  localparam int Q      = 1 << QB;
  localparam int SYM_W  = QB + 1;
  localparam int PART_W = 2 * (DATA_W + SYM_W + LW + 3);

  ts_state_e st_q;
  logic [KW-1:0]            path_q;
  logic [LW-1:0]            lvl_q;
  logic signed [SYM_W-1:0]  sym_q [L];
  logic [DIST_W-1:0]        dist_q;

  logic signed [DATA_W-1:0] r_mat [L][L];
  logic signed [DATA_W-1:0] y_vec [L];
  logic signed [DATA_W-1:0] inv_vec [L];
  logic signed [DATA_W-1:0] r_row [L];

  logic                     idle;
  logic                     top_lvl;
  logic [QB-1:0]            top_idx;
  logic signed [SYM_W-1:0]  top_sym;
  logic signed [SYM_W-1:0]  pe_sym;
  logic [PART_W-1:0]        pe_part;
  logic [DIST_W-1:0]        acc_base;
  logic [DIST_W-1:0]        acc_sum;
  logic [L*SYM_W-1:0]       sym_flat;

  assign idle = (st_q == ST_IDLE);

  ts_coef_store #(
    .L      (L),
    .DATA_W (DATA_W)
  ) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (ld_valid_i & idle),
    .sel_i   (ld_sel_i),
    .row_i   (ld_row_i),
    .col_i   (ld_col_i),
    .data_i  (ld_data_i),
    .r_o     (r_mat),
    .y_o     (y_vec),
    .inv_o   (inv_vec)
  );

  always_comb begin
    for (int j = 0; j < L; j++) r_row[j] = r_mat[lvl_q][j];
  end

  // exhaustive top antenna: high level from upper index bits, low level from lower bits
  assign top_lvl = (lvl_q >= LW'(L - 2));
  assign top_idx = (lvl_q == LW'(L - 1)) ? path_q[KW-1:QB] : path_q[QB-1:0];
  assign top_sym = {top_idx, 1'b1} - SYM_W'(Q);

  ts_level_pe #(
    .L      (L),
    .Q      (Q),
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .PART_W (PART_W)
  ) i_pe (
    .lvl_i      (lvl_q),
    .top_i      (top_lvl),
    .top_sym_i  (top_sym),
    .r_row_i    (r_row),
    .y_i        (y_vec[lvl_q]),
    .inv_i      (inv_vec[lvl_q]),
    .path_sym_i (sym_q),
    .sym_o      (pe_sym),
    .part_o     (pe_part)
  );

  assign acc_base = (lvl_q == LW'(L - 1)) ? '0 : dist_q;

  ts_sat_acc #(
    .IN_W (PART_W),
    .DW   (DIST_W)
  ) i_acc (
    .base_i (acc_base),
    .add_i  (pe_part),
    .sum_o  (acc_sum)
  );

  // level 0 symbol is taken straight from the slicer
  for (genvar g = 0; g < L; g++) begin : g_flat
    if (g == 0) begin : g_lvl0
      assign sym_flat[g*SYM_W +: SYM_W] = pe_sym;
    end else begin : g_lvln
      assign sym_flat[g*SYM_W +: SYM_W] = sym_q[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      path_q       <= '0;
      lvl_q        <= '0;
      dist_q       <= '0;
      cand_valid_o <= 1'b0;
      cand_idx_o   <= '0;
      cand_dist_o  <= '0;
      cand_sym_o   <= '0;
      done_o       <= 1'b0;
      for (int j = 0; j < L; j++) sym_q[j] <= '0;
    end else begin
      cand_valid_o <= 1'b0;
      done_o       <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_RUN;
            path_q <= '0;
            lvl_q  <= LW'(L - 1);
          end
        end
        ST_RUN: begin
          sym_q[lvl_q] <= pe_sym;
          dist_q       <= acc_sum;
          if (lvl_q == '0) begin
            cand_valid_o <= 1'b1;
            cand_idx_o   <= path_q;
            cand_dist_o  <= acc_sum;
            cand_sym_o   <= sym_flat;
            lvl_q        <= LW'(L - 1);
            if (path_q == KW'(M - 1)) st_q <= ST_FIN;
            else                      path_q <= path_q + 1'b1;
          end else begin
            lvl_q <= lvl_q - 1'b1;
          end
        end
        ST_FIN: begin
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ts_cand_gen_chk.sv
module ts_cand_gen_chk #(
  parameter int NT = 2,
  parameter int M  = 16
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            cand_valid_o,
  input logic [$clog2(M)-1:0]            cand_idx_o,
  input logic [2*NT*($clog2(M)/2+1)-1:0] cand_sym_o,
  input logic                            done_o
);

  localparam int L     = 2 * NT;
  localparam int KW    = $clog2(M);
  localparam int QB    = KW / 2;
  localparam int Q     = 1 << QB;
  localparam int SYM_W = QB + 1;

  logic [KW-1:0]    last_idx_q;
  logic [SYM_W-1:0] exp_hi;
  logic [SYM_W-1:0] exp_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           last_idx_q <= '0;
    else if (cand_valid_o) last_idx_q <= cand_idx_o;
  end

  assign exp_hi = {cand_idx_o[KW-1:QB], 1'b1} - SYM_W'(Q);
  assign exp_lo = {cand_idx_o[QB-1:0], 1'b1} - SYM_W'(Q);

  AST_TOP_SYMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> (cand_sym_o[(L-1)*SYM_W +: SYM_W] == exp_hi)
                  && (cand_sym_o[(L-2)*SYM_W +: SYM_W] == exp_lo)); // R2

  for (genvar g = 0; g < L; g++) begin : g_odd
    AST_SYM_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cand_valid_o |-> cand_sym_o[g*SYM_W]); // R3
  end

  AST_IDX_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_o && cand_idx_o != '0) |-> (cand_idx_o == last_idx_q + 1'b1)); // R6

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |=> !cand_valid_o); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(cand_valid_o) && $past(cand_idx_o) == KW'(M - 1))); // R7

  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && cand_valid_o)); // R7

endmodule

bind ts_cand_gen ts_cand_gen_chk #(
  .NT (NT),
  .M  (M)
) i_ts_cand_gen_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cand_valid_o (cand_valid_o),
  .cand_idx_o   (cand_idx_o),
  .cand_sym_o   (cand_sym_o),
  .done_o       (done_o)
);

// File: tb/test_ts_cand_gen.sv
module test_ts_cand_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 2;
  localparam int M  = 16;
  localparam int L  = 2 * NT;
  localparam int LW = $clog2(L);
  localparam int KW = $clog2(M);
  localparam int Q  = 4;
  localparam int SW = 3;
  localparam int DW = 32;
  localparam longint DMAX = (64'd1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ld_valid_i = 1'b0;
  logic [1:0] ld_sel_i = '0;
  logic [LW-1:0] ld_row_i = '0;
  logic [LW-1:0] ld_col_i = '0;
  logic [15:0] ld_data_i = '0;
  logic start_i = 1'b0;
  logic cand_valid_o;
  logic [KW-1:0] cand_idx_o;
  logic [DW-1:0] cand_dist_o;
  logic [L*SW-1:0] cand_sym_o;
  logic done_o;

  int n_chk = 0;
  int n_fail = 0;

  longint mr [L][L];
  longint my [L];
  longint mi [L];
  longint exp_dist [M];
  int     exp_sym [M][L];

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_cand_gen #(.NT(NT), .M(M)) i_ts_cand_gen (
    .clk_i(clk), .rst_ni(rst_ni), .ld_valid_i(ld_valid_i), .ld_sel_i(ld_sel_i),
    .ld_row_i(ld_row_i), .ld_col_i(ld_col_i), .ld_data_i(ld_data_i), .start_i(start_i),
    .cand_valid_o(cand_valid_o), .cand_idx_o(cand_idx_o), .cand_dist_o(cand_dist_o),
    .cand_sym_o(cand_sym_o), .done_o(done_o));

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic void model_store(int sel, int row, int col, longint val);
    if (sel == 0) mr[row][col] = val;
    else if (sel == 1) my[row] = val;
    else if (sel == 2) mi[row] = val;
  endfunction

  function automatic void compute_model();
    for (int k = 0; k < M; k++) begin
      longint d = 0;
      int s [L];
      for (int t = L - 1; t >= 0; t--) begin
        longint b = my[t];
        longint e;
        for (int j = t + 1; j < L; j++) b -= mr[t][j] * s[j];
        if (t == L - 1) s[t] = 2 * (k / Q) - (Q - 1);
        else if (t == L - 2) s[t] = 2 * (k % Q) - (Q - 1);
        else begin
          longint z = b * mi[t];
          longint f = z >>> 25;
          if (f > Q/2 - 1) f = Q/2 - 1;
          if (f < -(Q/2)) f = -(Q/2);
          s[t] = int'(2 * f + 1);
        end
        e = b - mr[t][t] * s[t];
        d += e * e;
        if (d > DMAX) d = DMAX;
      end
      exp_dist[k] = d;
      for (int t = 0; t < L; t++) exp_sym[k][t] = s[t];
    end
  endfunction

  task automatic load(int sel, int row, int col, int val, bit track);
    @(negedge clk);
    ld_valid_i = 1'b1; ld_sel_i = 2'(sel); ld_row_i = LW'(row);
    ld_col_i = LW'(col); ld_data_i = 16'(val);
    @(negedge clk);
    ld_valid_i = 1'b0;
    if (track) model_store(sel, row, col, longint'(val));
  endtask

  // tag names the requirement the run is aimed at; poke injects start and a write mid-search
  task automatic run(string tag, bit poke, bit with_ld, int ld_val);
    @(negedge clk);
    start_i = 1'b1;
    if (with_ld) begin
      ld_valid_i = 1'b1; ld_sel_i = 2'd1; ld_row_i = '0; ld_data_i = 16'(ld_val);
      model_store(1, 0, 0, longint'(ld_val));
    end
    compute_model();
    @(negedge clk);
    start_i = 1'b0; ld_valid_i = 1'b0;
    for (int c = 1; c <= L * M + 2; c++) begin
      if (poke && c == 3) begin
        start_i = 1'b1; ld_valid_i = 1'b1; ld_sel_i = 2'd1; ld_row_i = '0; ld_data_i = 16'd12345;
      end else begin
        start_i = 1'b0; ld_valid_i = 1'b0;
      end
      @(negedge clk);
      begin
        bit ev = (c % L == 0) && (c <= L * M);
        bit ed = (c == L * M + 1);
        check(cand_valid_o == ev, {"R6 ", tag}, "valid", longint'(cand_valid_o), longint'(ev));
        check(done_o == ed, {"R7 ", tag}, "done", longint'(done_o), longint'(ed));
        if (ev) begin
          int k = c / L - 1;
          check(int'(cand_idx_o) == k, {"R6 ", tag}, "index", longint'(cand_idx_o), longint'(k));
          check(longint'(cand_dist_o) == exp_dist[k], (exp_dist[k] == DMAX) ? {"R5 ", tag} : {"R4 ", tag},
                "distance", longint'(cand_dist_o), exp_dist[k]);
          for (int t = 0; t < L; t++) begin
            int sa = int'($signed(cand_sym_o[t*SW +: SW]));
            check(sa == exp_sym[k][t], (t >= L - 2) ? {"R2 ", tag} : {"R3 ", tag},
                  $sformatf("symbol path %0d level %0d", k, t), longint'(sa), longint'(exp_sym[k][t]));
          end
        end
      end
    end
  endtask

  task automatic load_all();
    for (int t = 0; t < L; t++) begin
      for (int j = t; j < L; j++) load(0, t, j, int'(mr[t][j]), 1'b1);
      load(1, t, 0, int'(my[t]), 1'b1);
      load(2, t, 0, int'(mi[t]), 1'b1);
    end
  endtask

  task automatic set_zero();
    for (int t = 0; t < L; t++) begin
      my[t] = 0; mi[t] = 0;
      for (int j = 0; j < L; j++) mr[t][j] = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    set_zero();
    repeat (3) @(negedge clk);
    check(cand_valid_o == 1'b0 && done_o == 1'b0, "R1", "flags in reset",
          longint'({cand_valid_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(cand_valid_o == 1'b0 && done_o == 1'b0, "R1", "flags after reset",
          longint'({cand_valid_o, done_o}), 0);
    check(cand_dist_o == '0 && cand_idx_o == '0 && cand_sym_o == '0, "R1", "outputs after reset",
          longint'(cand_dist_o), 0);

    // identity channel: slicer sees y directly; y1 on an even point, y0 beyond the edge
    for (int t = 0; t < L; t++) begin mr[t][t] = 4096; mi[t] = 4096; end
    my[3] = 2048; my[2] = -5120; my[1] = 8192; my[0] = -20480;
    load_all();
    run("R3", 1'b0, 1'b0, 0);

    // general channel with off-diagonal coupling
    for (int t = 0; t < L; t++) begin
      int d = 2048 + int'($urandom_range(6144));
      mr[t][t] = d;
      mi[t] = (16777216 + d / 2) / d;
      for (int j = t + 1; j < L; j++) mr[t][j] = int'($urandom_range(32768)) - 16384;
      my[t] = int'($urandom_range(40000)) - 20000;
    end
    load_all();
    run("R4", 1'b0, 1'b0, 0);

    // start and write injected mid-search, then rerun without reload
    run("R8", 1'b1, 1'b0, 0);
    run("R8", 1'b0, 1'b0, 0);

    // unused select code leaves storage untouched
    load(3, 0, 0, 7777, 1'b0);
    run("R10", 1'b0, 1'b0, 0);

    // write together with start is used by that search
    run("R9", 1'b0, 1'b1, -9000);

    // strong coupling drives distances into saturation
    for (int t = 0; t < L; t++) begin
      mr[t][t] = 4096; mi[t] = 4096; my[t] = 32767;
      for (int j = t + 1; j < L; j++) mr[t][j] = -32768;
    end
    load_all();
    run("R5", 1'b0, 1'b0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule